// File: doc/BRIEF.md
# Watchdog External Reset Pulse Generator

This block produces the timed reset pulse that a watchdog drives onto an external pin when it expires. A single-cycle trigger from the watchdog core starts the pulse. The pulse lasts a programmable number of microseconds, counted on a 1 MHz tick enable that is supplied from outside. The block drives a pad data value and a pad output-enable, so one output can act either as a push-pull driver or as an open-drain driver. The pulse can be active high or active low.

All settings live in one 32-bit configuration word. Its low field holds the pulse length minus one, in microseconds. The two top bits report the polarity and the drive mode. Software can change those two settings only by placing an agreed key code in the top byte of a write. Any other top byte leaves polarity and drive untouched, and the length field is still written. The width of the length field is a parameter: 20 bits by default, and 8 bits in a reduced variant.

Top module: `extrpulse_gen`

## Requirements
- R1: After reset the configuration reads 0x000000FF (length field 255, active-low, open-drain), pad_out is 1 and pad_oe is 0.
- R2: Every write stores cfg_wdata[WIDTH_BITS-1:0] into the length field, whatever the top byte holds. The field reads back at cfg_rdata[WIDTH_BITS-1:0] from the cycle after the write.
- R3: A write whose top byte cfg_wdata[31:24] is 0xA5 selects active-high polarity, and 0x5A selects active-low. Polarity reads back at cfg_rdata[31], with 1 meaning active-high.
- R4: A write whose top byte is 0xA8 selects push-pull drive, and 0x8A selects open-drain. Drive mode reads back at cfg_rdata[30], with 1 meaning push-pull.
- R5: A write with any other top byte leaves cfg_rdata[31] and cfg_rdata[30] unchanged.
- R6: cfg_rdata[29:WIDTH_BITS] always reads zero.
- R7: A trigger while idle asserts the pulse from the next cycle. With N the length field held before that clock edge, the pulse stays asserted for exactly N+1 tick cycles and releases in the cycle after the last of them. A tick in the trigger cycle does not count.
- R8: A trigger while a pulse is in progress is ignored and does not change the pulse length.
- R9: A write to the length field during a pulse does not change that pulse. The new value applies to the next pulse.
- R10: When asserted, the pad level is 1 for active-high and 0 for active-low. When not asserted, it is the opposite level. In push-pull mode pad_oe is always 1. In open-drain mode pad_oe is 1 exactly when pad_out is 0.
- R11: A change of polarity or drive mode reaches the pads in the cycle after the write, including during a pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_us | input | 1 | One-cycle enable at 1 MHz |
| trigger | input | 1 | One-cycle expiry request from the watchdog |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read value |
| pad_out | output | 1 | Pad data level |
| pad_oe | output | 1 | Pad output-enable |

## Verification
A configuration write and a trigger can arrive in the same clock cycle. The design resolves this so that the pulse takes its length from the field held before the write, and the written value serves the following pulse. The bench provokes this by writing a new length on the very cycle it raises the trigger. It then counts the ticks under the asserted pad and requires the old length plus one, then the new length plus one on the next pulse. A second pair, a trigger on the final tick of a running pulse, is driven by holding the trigger high for the whole pulse. The measured length must still match the programmed value.

// File: rtl/extrpulse_pkg.sv
package extrpulse_pkg;
    localparam int unsigned CFG_BITS = 32;
    localparam logic [7:0] KEY_ACT_HIGH   = 8'hA5;
    localparam logic [7:0] KEY_ACT_LOW    = 8'h5A;
    localparam logic [7:0] KEY_PUSH_PULL  = 8'hA8;
    localparam logic [7:0] KEY_OPEN_DRAIN = 8'h8A;

    typedef struct packed {
        logic act_high;
        logic push_pull;
    } pad_mode_t;
endpackage

// File: rtl/extrpulse_cfg.sv
module extrpulse_cfg
    import extrpulse_pkg::*;
#(
    parameter int unsigned WIDTH_BITS = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [CFG_BITS-1:0]   wdata,
    output logic [WIDTH_BITS-1:0] width_o,
    output pad_mode_t             mode_o,
    output logic [CFG_BITS-1:0]   rdata
);
    localparam int unsigned ZERO_BITS = CFG_BITS - 2 - WIDTH_BITS;
    localparam logic [WIDTH_BITS-1:0] WIDTH_RST = WIDTH_BITS'(8'hFF);

    typedef struct packed {
        pad_mode_t             mode;
        logic [WIDTH_BITS-1:0] width;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic [7:0] key;

    assign key = wdata[CFG_BITS-1 -: 8];

    always_comb begin
        cfg_d = cfg_q;
        if (we) begin
            cfg_d.width = wdata[WIDTH_BITS-1:0];
            case (key)
                KEY_ACT_HIGH:   cfg_d.mode.act_high  = 1'b1;
                KEY_ACT_LOW:    cfg_d.mode.act_high  = 1'b0;
                KEY_PUSH_PULL:  cfg_d.mode.push_pull = 1'b1;
                KEY_OPEN_DRAIN: cfg_d.mode.push_pull = 1'b0;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.width          <= WIDTH_RST;
            cfg_q.mode.act_high  <= 1'b0;
            cfg_q.mode.push_pull <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    generate
        if (WIDTH_BITS < CFG_BITS - 8) begin : g_mid
            logic unused_mid_bits;
            assign unused_mid_bits = ^wdata[CFG_BITS-9:WIDTH_BITS];
        end
    endgenerate

    assign width_o = cfg_q.width;
    assign mode_o  = cfg_q.mode;
    assign rdata   = {cfg_q.mode.act_high, cfg_q.mode.push_pull,
                      {ZERO_BITS{1'b0}}, cfg_q.width};
endmodule

// File: rtl/extrpulse_timer.sv
module extrpulse_timer #(
    parameter int unsigned WIDTH_BITS = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  tick,
    input  logic                  trigger,
    input  logic [WIDTH_BITS-1:0] width_i,
    output logic                  busy_o,
    output logic [WIDTH_BITS-1:0] count_o
);
    typedef struct packed {
        logic                  busy;
        logic [WIDTH_BITS-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!tmr_q.busy) begin
            if (trigger) begin
                tmr_d.busy = 1'b1;
                tmr_d.cnt  = width_i;
            end
        end else if (tick) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.busy = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy_o  = tmr_q.busy;
    assign count_o = tmr_q.cnt;
endmodule

// File: rtl/extrpulse_pad.sv
module extrpulse_pad
    import extrpulse_pkg::*;
(
    input  logic      busy_i,
    input  pad_mode_t mode_i,
    output logic      pad_out,
    output logic      pad_oe
);
    logic level_d;

    always_comb begin
        level_d = busy_i ? mode_i.act_high : !mode_i.act_high;
        pad_out = level_d;
        pad_oe  = mode_i.push_pull ? 1'b1 : !level_d;
    end
endmodule

// File: rtl/extrpulse_gen.sv
module extrpulse_gen
    import extrpulse_pkg::*;
#(
    parameter int unsigned WIDTH_BITS = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick_us,
    input  logic        trigger,
    input  logic        cfg_we,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic        pad_out,
    output logic        pad_oe
);
    logic [WIDTH_BITS-1:0] width_w;
    logic [WIDTH_BITS-1:0] cnt_w;
    pad_mode_t             mode_w;
    logic                  busy_w;

    extrpulse_cfg #(.WIDTH_BITS(WIDTH_BITS)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .width_o (width_w),
        .mode_o  (mode_w),
        .rdata   (cfg_rdata)
    );

    extrpulse_timer #(.WIDTH_BITS(WIDTH_BITS)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_us),
        .trigger (trigger),
        .width_i (width_w),
        .busy_o  (busy_w),
        .count_o (cnt_w)
    );

    extrpulse_pad u_pad (
        .busy_i  (busy_w),
        .mode_i  (mode_w),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );
endmodule

// File: rtl/extrpulse_chk.sv
module extrpulse_chk #(
    parameter int unsigned WIDTH_BITS = 20
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  tick_us,
    input logic                  trigger,
    input logic                  cfg_we,
    input logic [7:0]            wr_key,
    input logic [WIDTH_BITS-1:0] wr_width,
    input logic [31:0]           cfg_rdata,
    input logic                  pad_out,
    input logic                  pad_oe,
    input logic                  busy,
    input logic [WIDTH_BITS-1:0] cnt
);
    // R7
    start_on_idle_trigger_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && trigger) |=> busy);
    // R8
    retrigger_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && trigger && !tick_us) |=> (busy && $stable(cnt)));
    // R7
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick_us) |=> (busy && $stable(cnt)));
    // R7
    end_after_last_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && tick_us && cnt == '0) |=> !busy);
    // R2
    width_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we |=> (cfg_rdata[WIDTH_BITS-1:0] == $past(wr_width)));
    // R5
    polarity_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && wr_key != 8'hA5 && wr_key != 8'h5A) |=> $stable(cfg_rdata[31]));
    // R5
    drive_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && wr_key != 8'hA8 && wr_key != 8'h8A) |=> $stable(cfg_rdata[30]));
    // R6
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[29:WIDTH_BITS] == '0);
    // R10
    push_pull_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[30] |-> pad_oe);
    // R10
    open_drain_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rdata[30] |-> (pad_oe == !pad_out));
    // R10
    pad_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pad_out == (busy ? cfg_rdata[31] : !cfg_rdata[31]));
endmodule

bind extrpulse_gen extrpulse_chk #(.WIDTH_BITS(WIDTH_BITS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick_us   (tick_us),
    .trigger   (trigger),
    .cfg_we    (cfg_we),
    .wr_key    (cfg_wdata[31:24]),
    .wr_width  (cfg_wdata[WIDTH_BITS-1:0]),
    .cfg_rdata (cfg_rdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .busy      (busy_w),
    .cnt       (cnt_w)
);

// File: tb/tb_extrpulse_gen.sv
module tb_extrpulse_gen;
    localparam int W = 20;
    localparam int TICK_DIV = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_us = 1'b0;
    logic        trigger = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        pad_out, pad_oe;

    int n_cmp = 0;
    int n_bad = 0;
    int ph = 0;
    bit m_hi = 1'b0;
    bit m_pp = 1'b0;
    logic [W-1:0] m_w = W'(8'hFF);

    always #4 clk = ~clk;

    extrpulse_gen #(.WIDTH_BITS(W)) dut (
        .clk(clk), .rst_n(rst_n), .tick_us(tick_us), .trigger(trigger),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pad_out(pad_out), .pad_oe(pad_oe)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        tick_us = (ph % TICK_DIV == 0);
        ph++;
    endtask

    function automatic logic [31:0] model_rd();
        return {m_hi, m_pp, 10'b0, m_w};
    endfunction

    function automatic void model_wr(logic [31:0] d);
        m_w = d[W-1:0];
        case (d[31:24])
            8'hA5: m_hi = 1'b1;
            8'h5A: m_hi = 1'b0;
            8'hA8: m_pp = 1'b1;
            8'h8A: m_pp = 1'b0;
            default: ;
        endcase
    endfunction

    task automatic cfg_write(string req, logic [31:0] d);
        step();
        cfg_we = 1'b1;
        cfg_wdata = d;
        step();
        cfg_we = 1'b0;
        model_wr(d);
        check(req, cfg_rdata, model_rd());
    endtask

    // mode 0: plain, 1: trigger held through pulse (R8), 2: width write mid-pulse (R9)
    task automatic measure(string req, int mode, int exp_len);
        int cnt = 0;
        int guard = 0;
        bit lvl_bad = 1'b0;
        logic [31:0] wr_mid = 32'h0000_0001;
        check({req, " start"}, {31'b0, pad_out}, {31'b0, m_hi});
        while (pad_out == m_hi && guard < 5000) begin
            if (pad_oe !== (m_pp ? 1'b1 : !pad_out)) lvl_bad = 1'b1;
            if (tick_us) cnt++;
            trigger = (mode == 1);
            cfg_we = (mode == 2 && guard == 1);
            cfg_wdata = wr_mid;
            guard++;
            step();
        end
        trigger = 1'b0;
        cfg_we = 1'b0;
        if (mode == 2) model_wr(wr_mid);
        check({req, " length"}, cnt, exp_len);
        check("R10 oe during pulse", {31'b0, lvl_bad}, 32'd0);
        check("R10 idle level", {30'b0, pad_out, pad_oe}, {30'b0, !m_hi, (m_pp ? 1'b1 : m_hi)});
    endtask

    task automatic pulse(string req, int mode);
        int exp_len = int'(m_w) + 1;
        step();
        trigger = 1'b1;
        step();
        trigger = 1'b0;
        measure(req, mode, exp_len);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        check("R1 reset readback", cfg_rdata, 32'h0000_00FF);
        check("R1 reset pads", {30'b0, pad_out, pad_oe}, 32'b10);
        // R7 default length 256 ticks
        pulse("R1 R7 default pulse", 0);

        // R3 R4 R7 R10 sweep over polarity, drive and short lengths
        for (int hi = 0; hi < 2; hi++) begin
            for (int pp = 0; pp < 2; pp++) begin
                for (int w = 0; w < 12; w++) begin
                    cfg_write("R3 polarity key", {(hi != 0) ? 8'hA5 : 8'h5A, 24'(w)});
                    cfg_write("R4 drive key", {(pp != 0) ? 8'hA8 : 8'h8A, 24'(w)});
                    pulse("R7 R10 sweep pulse", 0);
                end
            end
        end

        // R2 R5 R6 every top byte
        for (int b = 0; b < 256; b++) begin
            cfg_write("R2 R5 R6 key sweep", {8'(b), 24'((b * 4093 + 7) & 24'hFFFFFF)});
        end

        // R8 trigger held during whole pulse
        cfg_write("R2 set length", 32'h0000_0006);
        pulse("R8 retrigger ignored", 1);
        // R9 width write mid pulse, new value on next pulse
        cfg_write("R2 set length", 32'h0000_0009);
        pulse("R9 mid-pulse write", 2);
        pulse("R9 next pulse uses new width", 0);

        // R7 same-cycle write and trigger: old width applies
        cfg_write("R2 set length", 32'h0000_0009);
        step();
        trigger = 1'b1;
        cfg_we = 1'b1;
        cfg_wdata = 32'h0000_0003;
        step();
        trigger = 1'b0;
        cfg_we = 1'b0;
        measure("R7 write with trigger", 0, 10);
        model_wr(32'h0000_0003);
        pulse("R7 following pulse", 0);

        // R11 polarity flip mid pulse reaches pad next cycle
        cfg_write("R3 active-low", 32'h5A00_0014);
        cfg_write("R4 push-pull", 32'hA800_0014);
        step();
        trigger = 1'b1;
        step();
        trigger = 1'b0;
        repeat (3) step();
        check("R11 asserted low", {31'b0, pad_out}, 32'd0);
        cfg_we = 1'b1;
        cfg_wdata = 32'hA500_0014;
        step();
        cfg_we = 1'b0;
        model_wr(32'hA500_0014);
        check("R11 flipped to high mid pulse", {30'b0, pad_out, pad_oe}, 32'b11);
        cfg_we = 1'b1;
        cfg_wdata = 32'h8A00_0014;
        step();
        cfg_we = 1'b0;
        model_wr(32'h8A00_0014);
        check("R11 open-drain mid pulse", {30'b0, pad_out, pad_oe}, 32'b10);
        repeat (200) step();
        check("R11 idle after pulse", {30'b0, pad_out, pad_oe}, 32'b01);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule